// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Engine

This block is a byte-wide SPI engine that a processor sets up through a small register bus. One 8-bit control register sets the role (bus master or slave), the SCK polarity and phase, an enable bit and an option to ignore the select line. It also holds a three-bit rate code. The rate code picks an SCK rate of the system clock divided by 4, 8, 16, 32, 64 or 128. A data register loads the byte to be sent and returns the byte last received. A status register reports a completion flag and a busy bit.

As master, the block starts a transfer when the data register is written. It drives SCK and its serial output and samples its serial input. As slave, it passes the external SCK, select and serial input through a two-flop synchronizer and finds the clock edges in the system clock domain. For this reason the system clock must run at least four times faster than SCK. Clearing the enable bit acts as a local reset: any transfer in progress stops and the shift state is cleared.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset the control register (address 0) reads 8'h14, the status register (address 2) reads 8'h00 and sck_o is low. The control bits from bit 7 down to bit 0 are: rate bit 2, enable, select-ignore, master, polarity, phase, rate bit 1, rate bit 0.
- R2: Rate code c = {bit7,bit1,bit0} from 1 to 6 gives SCK = clk/(4<<(c-1)). A master transfer sets the status done bit 8*(4<<(c-1)) clock cycles after the clock edge that takes the data write.
- R3: Rate codes 0 and 7 are reserved. With either code, a data write in master mode starts nothing: the busy bit stays 0 and sck_o stays at its idle level.
- R4: Whenever no master transfer is running, sck_o equals the polarity bit (0 gives idle low, 1 gives idle high).
- R5: The master sends its byte MSB first. With phase 0 each bit is valid on the serial output before and at the SCK edge that leaves idle. With phase 1 each bit is valid at the SCK edge that returns to idle.
- R6: At the end of a transfer, status bit 7 (done) is set and the data register (address 1) returns the received byte. Writing the status register clears done.
- R7: While the enable bit is 0 the engine is held in reset. A transfer in progress aborts: busy drops, sck_o returns to idle, and done is not set.
- R8: A slave with SS low shifts in eight bits from sdi_i MSB first and returns its loaded byte on sdo_o MSB first, using the same phase rules as R5. After the eighth sampling edge it sets done.
- R9: A slave whose select-ignore bit is 0 ignores SCK while SS is high: no bit is taken and done stays 0.
- R10: A slave with select-ignore set and phase 1 completes a transfer with SS held high.
- R11: A slave with select-ignore set and phase 0 still needs SS: with SS high it completes nothing.
- R12: Status bit 0 (busy) reads 1 while a master transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sck_o | output | 1 | SCK driven in master mode, idle level otherwise |
| sck_i | input | 1 | External SCK in slave mode |
| ss_n_i | input | 1 | Active-low slave select in slave mode |
| sdo_o | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sdi_i | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
Some properties are checked by assertions on every cycle. A transfer never starts under a reserved rate code. SCK sits at its idle level whenever the engine is not busy. A cleared enable bit leaves neither busy nor done set one cycle later. Every completion raises the done flag. A slave with its select blocked never takes a sampling edge. Other behaviour needs the bench's scenarios: the exact cycle count for each divider, the MSB-first bit order under each polarity and phase, the slave's returned byte, and the abort in the middle of a transfer.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 8;
  localparam int EDGE_W = $clog2(2 * BYTE_W);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h14;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  typedef struct packed {
    logic rate2;
    logic en;
    logic ss_ign;
    logic master;
    logic pol;
    logic pha;
    logic rate1;
    logic rate0;
  } ctrl_t;

  function automatic logic rate_ok(input logic [2:0] code);
    return (code != 3'd0) && (code != 3'd7);
  endfunction

  // half SCK period in system clocks: divider/2 = 2 << (code-1) = 1 << code
  function automatic logic [HALF_W-1:0] half_period(input logic [2:0] code);
    return HALF_W'(1) << code;
  endfunction
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] half,
  output logic          toggle_o,
  output logic          phase_o
);
  logic [CW-1:0] cnt_q;

  assign toggle_o = run && (cnt_q == half - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (clr || !run) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (toggle_o) begin
      cnt_q   <= '0;
      phase_o <= ~phase_o;
    end else begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= INIT;
      sync_o <= INIT;
      prev_o <= INIT;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
      prev_o <= sync_o;
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         sample,
  input  logic         sample_bit,
  input  logic         launch,
  output logic [W-1:0] cap_o,
  output logic         out_bit_o
);
  logic [W-1:0] sr_q;

  assign cap_o = sample ? {sr_q[W-2:0], sample_bit} : sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q      <= '0;
      out_bit_o <= 1'b0;
    end else if (clr) begin
      sr_q      <= '0;
      out_bit_o <= 1'b0;
    end else if (load) begin
      sr_q      <= load_val;
      out_bit_o <= load_val[W-1];
    end else begin
      if (sample) sr_q <= {sr_q[W-2:0], sample_bit};
      if (launch) out_bit_o <= sr_q[W-1];
    end
  end
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              sck_o,
  input  logic              sck_i,
  input  logic              ss_n_i,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BYTE_W - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BYTE_W - 1);

  ctrl_t             ctrl_q;
  logic [2:0]        rate;
  logic              en, pol, pha;
  logic              mst_mode, slv_mode, rate_valid;
  logic              wr_ctrl, wr_data, wr_stat;
  logic              busy_q, done_q;
  logic [BYTE_W-1:0] rx_q;

  assign rate       = {ctrl_q.rate2, ctrl_q.rate1, ctrl_q.rate0};
  assign en         = ctrl_q.en;
  assign pol        = ctrl_q.pol;
  assign pha        = ctrl_q.pha;
  assign mst_mode   = en && ctrl_q.master;
  assign slv_mode   = en && !ctrl_q.master;
  assign rate_valid = rate_ok(rate);

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_data = reg_we && (reg_addr == A_DATA);
  assign wr_stat = reg_we && (reg_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= ctrl_t'(CTRL_RST);
    else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata);
  end

  // ---------------- master side ----------------
  logic              start_evt, tog, phase;
  logic              m_lead, m_trail, m_sample, m_launch, m_last;
  logic [EDGE_W-1:0] edge_cnt_q;

  assign start_evt = wr_data && mst_mode && rate_valid && !busy_q;

  spi_sck_gen #(.CW(HALF_W)) u_sck_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!mst_mode),
    .run      (busy_q),
    .half     (half_period(rate)),
    .toggle_o (tog),
    .phase_o  (phase)
  );

  assign m_lead   = tog && !phase;
  assign m_trail  = tog && phase;
  assign m_sample = pha ? m_trail : m_lead;
  assign m_launch = pha ? m_lead : m_trail;
  assign m_last   = m_trail && (edge_cnt_q == LAST_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      edge_cnt_q <= '0;
    end else if (!mst_mode) begin
      busy_q     <= 1'b0;
      edge_cnt_q <= '0;
    end else begin
      if (start_evt)   busy_q <= 1'b1;
      else if (m_last) busy_q <= 1'b0;
      if (!busy_q)     edge_cnt_q <= '0;
      else if (tog)    edge_cnt_q <= edge_cnt_q + EDGE_W'(1);
    end
  end

  assign sck_o = pol ^ phase;

  // ---------------- slave side ----------------
  logic [2:0]       syn, syn_p;
  logic             sck_s, sck_p, ss_s, sdi_s;
  logic             ss_bypass, s_active, ss_block;
  logic             s_chg, s_lead, s_trail, s_sample, s_launch, s_last;
  logic [BIT_W-1:0] s_cnt_q;

  spi_in_sync #(.W(3), .INIT(3'b010)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sck_i, ss_n_i, sdi_i}),
    .sync_o  (syn),
    .prev_o  (syn_p)
  );

  assign sck_s = syn[2];
  assign ss_s  = syn[1];
  assign sdi_s = syn[0];
  assign sck_p = syn_p[2];

  // select-ignore only takes effect for a slave with phase 1
  assign ss_bypass = ctrl_q.ss_ign && pha;
  assign s_active  = slv_mode && (ss_bypass || !ss_s);
  assign ss_block  = slv_mode && !s_active;

  assign s_chg    = s_active && (sck_s != sck_p);
  assign s_lead   = s_chg && (sck_s != pol);
  assign s_trail  = s_chg && (sck_s == pol);
  assign s_sample = pha ? s_trail : s_lead;
  assign s_launch = (pha ? s_lead : s_trail) || ss_block;
  assign s_last   = s_sample && (s_cnt_q == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         s_cnt_q <= '0;
    else if (!s_active) s_cnt_q <= '0;
    else if (s_sample)  s_cnt_q <= s_cnt_q + BIT_W'(1);
  end

  // ---------------- shared shifter and status ----------------
  logic              sample_evt, done_evt;
  logic [BYTE_W-1:0] cap;

  assign sample_evt = m_sample || s_sample;
  assign done_evt   = m_last || s_last;

  spi_shifter #(.W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!en),
    .load       (start_evt || (wr_data && slv_mode)),
    .load_val   (reg_wdata),
    .sample     (sample_evt),
    .sample_bit (mst_mode ? sdi_i : sdi_s),
    .launch     (m_launch || s_launch),
    .cap_o      (cap),
    .out_bit_o  (sdo_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      rx_q   <= '0;
    end else if (!en) begin
      done_q <= 1'b0;
    end else if (done_evt) begin
      done_q <= 1'b1;
      rx_q   <= cap;
    end else if (wr_stat || wr_data) begin
      done_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_DATA:  reg_rdata = rx_q;
      A_STAT:  reg_rdata = {done_q, {(BYTE_W-2){1'b0}}, busy_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic pol,
  input logic busy,
  input logic sck,
  input logic start_evt,
  input logic rate_valid,
  input logic done_evt,
  input logic done_flag,
  input logic ss_block,
  input logic sample_evt
);
  AST_START_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> rate_valid); // R3

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == pol)); // R4

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !done_flag)); // R7

  AST_DONE_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done_flag); // R6

  AST_SS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ss_block |-> !sample_evt); // R9
endmodule

bind spi_ctl_top spi_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .pol        (pol),
  .busy       (busy_q),
  .sck        (sck_o),
  .start_evt  (start_evt),
  .rate_valid (rate_valid),
  .done_evt   (done_evt),
  .done_flag  (done_q),
  .ss_block   (ss_block),
  .sample_evt (sample_evt)
);

// File: tb/spi_ctl_top_tb_top.sv
module spi_ctl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       sck_o, sdo_o;
  logic       sck_in = 1'b0;
  logic       ss_n = 1'b1;
  logic       sdi_slv = 1'b0;
  logic       lb = 1'b1;
  logic       sdi;

  int  n_tests = 0;
  int  n_fail  = 0;
  logic tb_pol = 1'b0;
  logic tb_pha = 1'b0;
  logic mon_en = 1'b0;
  logic exp_q[$];

  always #2 clk = ~clk;

  assign sdi = lb ? sdo_o : sdi_slv;

  spi_ctl_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sck_o     (sck_o),
    .sck_i     (sck_in),
    .ss_n_i    (ss_n),
    .sdo_o     (sdo_o),
    .sdi_i     (sdi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] mctrl(input logic [2:0] code, input logic en,
                                       input logic pol, input logic pha);
    return {code[2], en, 1'b0, 1'b1, pol, pha, code[1:0]};
  endfunction

  // scoreboard monitor: at each master sampling edge pop the expected bit
  always @(sck_o) begin
    if (mon_en) begin
      logic lead;
      lead = (sck_o != tb_pol);
      if (lead != tb_pha) begin
        if (exp_q.size() == 0) chk("R5 extra sampling edge", 1, 0);
        else chk("R5 master bit order", sdo_o, exp_q.pop_front());
      end
    end
  end

  task automatic m_xfer(input logic [7:0] tx, input logic [2:0] code,
                        input logic pol, input logic pha);
    int n;
    int expn;
    logic [7:0] d;
    tb_pol = pol; tb_pha = pha; lb = 1'b1;
    wr(0, mctrl(code, 1'b1, pol, pha));
    wr(2, 8'h00);
    for (int i = 7; i >= 0; i--) exp_q.push_back(tx[i]);
    mon_en = 1'b1;
    expn = 32 << (code - 1);
    wr(1, tx);
    reg_addr = 2'd2;
    n = 0;
    do begin
      @(posedge clk); n++; #1;
      if (n == 1) chk("R12 busy during transfer", reg_rdata[0], 1'b1);
    end while (!reg_rdata[7] && n < 5000);
    mon_en = 1'b0;
    chk("R2 transfer length", n, expn);
    chk("R4 idle level after transfer", sck_o, pol);
    chk("R5 all bits seen", exp_q.size(), 0);
    exp_q.delete();
    rd(1, d);
    chk("R6 received byte", d, tx);
    wr(2, 8'h00);
    rd(2, d);
    chk("R6 done cleared by status write", d, 8'h00);
  endtask

  task automatic s_xfer(input string tag, input logic [7:0] mosi_b, input logic [7:0] miso_b,
                        input logic pha, input logic ssdis, input logic ss_low,
                        input logic exp_done);
    localparam int H = 16;
    logic [7:0] d;
    lb = 1'b0; sck_in = 1'b0; ss_n = 1'b1; sdi_slv = 1'b0;
    wait_clk(8);
    wr(0, {1'b0, 1'b1, ssdis, 1'b0, 1'b0, pha, 2'b01});
    wr(2, 8'h00);
    wr(1, miso_b);
    ss_n = !ss_low;
    wait_clk(H);
    for (int i = 7; i >= 0; i--) begin
      if (!pha) begin
        sdi_slv = mosi_b[i];
        wait_clk(H);
        if (exp_done) chk({tag, " slave out bit"}, sdo_o, miso_b[i]);
        sck_in = 1'b1;
        wait_clk(H);
        sck_in = 1'b0;
      end else begin
        sck_in = 1'b1;
        sdi_slv = mosi_b[i];
        wait_clk(H);
        if (exp_done) chk({tag, " slave out bit"}, sdo_o, miso_b[i]);
        sck_in = 1'b0;
        wait_clk(H);
      end
    end
    wait_clk(8);
    rd(2, d);
    chk({tag, " slave done"}, d[7], exp_done);
    if (exp_done) begin
      rd(1, d);
      chk({tag, " slave received byte"}, d, mosi_b);
    end
    ss_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    rd(0, d); chk("R1 control reset", d, 8'h14);
    rd(2, d); chk("R1 status reset", d, 8'h00);
    chk("R1 sck reset", sck_o, 1'b0);

    // R4 polarity while idle
    wr(0, mctrl(3'd1, 1'b1, 1'b1, 1'b0));
    wait_clk(1);
    chk("R4 idle high", sck_o, 1'b1);

    // R2/R5/R6/R12 across all divider codes and all four phase/polarity combos
    for (int c = 1; c <= 6; c++) begin
      m_xfer(8'hA5 ^ 8'(c * 37), 3'(c), c[0], c[1]);
    end
    m_xfer(8'h01, 3'd1, 1'b0, 1'b0);
    m_xfer(8'h80, 3'd2, 1'b1, 1'b1);

    // R3 reserved rate codes
    for (int k = 0; k < 2; k++) begin
      logic [2:0] code;
      code = (k == 0) ? 3'd0 : 3'd7;
      wr(0, mctrl(code, 1'b1, k[0], 1'b0));
      wr(1, 8'h5A);
      for (int t = 0; t < 40; t++) begin
        wait_clk(1);
        if (sck_o !== k[0] || reg_rdata[0] !== 1'b0) break;
      end
      reg_addr = 2'd2; #1;
      chk("R3 reserved code no busy", reg_rdata[0], 1'b0);
      chk("R3 reserved code sck idle", sck_o, k[0]);
    end

    // R7 abort mid-transfer
    lb = 1'b1;
    wr(0, mctrl(3'd3, 1'b1, 1'b1, 1'b0));
    wr(2, 8'h00);
    wr(1, 8'h3C);
    wait_clk(40);
    wr(0, mctrl(3'd3, 1'b0, 1'b1, 1'b0));
    wait_clk(1);
    rd(2, d);
    chk("R7 abort clears busy and done", d, 8'h00);
    chk("R7 abort sck idle", sck_o, 1'b1);
    wait_clk(200);
    rd(2, d);
    chk("R7 no completion after abort", d[7], 1'b0);

    // slave scenarios
    s_xfer("R8 pha0", 8'hC3, 8'h96, 1'b0, 1'b0, 1'b1, 1'b1);
    s_xfer("R8 pha1", 8'h2D, 8'hE1, 1'b1, 1'b0, 1'b1, 1'b1);
    s_xfer("R9 ss high", 8'h55, 8'hAA, 1'b1, 1'b0, 1'b0, 1'b0);
    s_xfer("R10 ignore ss pha1", 8'h69, 8'h17, 1'b1, 1'b1, 1'b0, 1'b1);
    s_xfer("R11 ignore ss pha0", 8'h4B, 8'h71, 1'b0, 1'b1, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule